// File: doc/BRIEF.md
# Stereo Output Channel Mode Processor

This block sits after the sample-rate domain of an audio output path. It receives one signed 24-bit left and right sample pair per frame and produces the two output channels. Each output channel has its own routing field. The field chooses silence, the right input, the left input or the half-sum mix of both inputs. Swapped stereo, straight stereo, dual mono and full silence all come from these two fields.

After routing, a soft-mute gain scales both channels. The gain moves by one step of 1/256 per accepted frame, so muting and un-muting never cause a sudden step. A zero-run watcher counts bit-clock ticks while the input stays all-zero. When zero detection is enabled and the count has reached 65,536, the watcher raises the zero-forced flag. The run control pin or the operation-enable pin forces both outputs to bipolar zero, which is the two's-complement value 0.

Samples enter and leave on valid/ready streams with a single output register. Back-pressure rules:
- `in_ready` is high whenever the output register is empty or is being drained in the same cycle.
- While `out_valid` is high and `out_ready` is low, the output pair and `out_valid` hold.
- A pair is accepted on a rising clock edge where both `in_valid` and `in_ready` are high. The processed pair appears on `out_left`/`out_right` from that same edge.

Top module: `chmode_proc`

## Requirements
- R1: The left output source is chosen by `route_sel[1:0]`: value 0 gives 0, value 1 gives the right input, value 2 gives the left input, and value 3 gives the mix.
- R2: The right output source is chosen by `route_sel[3:2]`, using the same values as R1. So 4'b0110 is straight stereo, 4'b1001 is swapped, 4'b1111 is dual mono and 4'b0000 is silence.
- R3: The mix is floor((L+R)/2), computed on a 25-bit sign-extended sum, so it never wraps. Two full-scale samples of the same sign give that same sample back.
- R4: The soft-mute gain g resets to 256.
  - Each accepted frame uses the current g: the output is floor(routed*g/256).
  - After a frame accepted with `mute_req` high, g drops by 1, but not below 0.
  - After a frame accepted with `mute_req` low, g rises by 1, but not above 256.
- R5: While `op_enable` is high, every accepted pair produces 0 on both outputs, and `zero_forced` is high.
- R6: While `run_n` is low, every accepted pair produces 0 on both outputs, and `zero_forced` is high.
- R7: The zero-run count works as follows.
  - It rises on each cycle with `bit_tick` high while the latest accepted pair is all-zero, and it saturates at 65,536.
  - When the count is saturated and `zero_det_en` is high, `zero_forced` is high and accepted zero pairs produce 0.
  - When `zero_det_en` is low, the flag stays low and zero data passes through normally.
- R8: Accepting a pair that is non-zero in either channel clears the zero-run count, so `zero_forced` falls at that edge. That pair passes through unforced.
- R9: `in_ready` = !`out_valid` || `out_ready`. While `out_valid` is high and `out_ready` is low, the outputs and `out_valid` hold.
- R10: After reset, `out_valid` is 0, `in_ready` is 1 and `zero_forced` is 0 (with `run_n` high and `op_enable` low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pair valid |
| in_ready | output | 1 | Block can accept a pair |
| in_left | input | 24 | Left input sample, signed |
| in_right | input | 24 | Right input sample, signed |
| out_valid | output | 1 | Output pair valid |
| out_ready | input | 1 | Downstream accepts the output pair |
| out_left | output | 24 | Left output sample, signed |
| out_right | output | 24 | Right output sample, signed |
| bit_tick | input | 1 | One-cycle pulse per serial bit clock |
| route_sel | input | 4 | Routing fields: [1:0] left output, [3:2] right output |
| mute_req | input | 1 | Soft-mute request |
| op_enable | input | 1 | High forces both outputs to zero |
| zero_det_en | input | 1 | Enables forcing after a long zero run |
| run_n | input | 1 | Low forces both outputs to zero |
| zero_forced | output | 1 | Outputs are being forced to zero |

## Verification
Routing is tried with distinct left and right values, so straight, swapped, both-from-one-side and silent settings each give a different pair. Mixed settings where only one channel mixes check that the two fields decode independently. The mix is tried with an odd negative sum, where floor and truncation give different results, and with both full-scale extremes, which would wrap in a 24-bit adder. The gain ramp uses a constant input whose scaled values are exact, so each of the 257 frames in either direction has its own expected value. The zero-run limit is checked one tick before and at saturation. The forcing controls are each checked alone against non-zero data.

// File: rtl/chmode_pkg.sv
package chmode_pkg;
  localparam int SAMPLE_W = 24;
  localparam int GAIN_FRAC = 8;
  localparam int ZRUN_LIMIT = 65536;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_RIGHT = 2'd1,
    SRC_LEFT  = 2'd2,
    SRC_MIX   = 2'd3
  } src_e;
endpackage

// File: rtl/chmode_route.sv
module chmode_route
  import chmode_pkg::*;
#(
  parameter int DW = SAMPLE_W
) (
  input  logic [DW-1:0] l_i,
  input  logic [DW-1:0] r_i,
  input  logic [1:0]    sel_i,
  output logic [DW-1:0] y_o
);
  logic signed [DW:0] sum_w;
  logic signed [DW:0] half_w;

  // 25-bit sign-extended sum then arithmetic halving (R3)
  assign sum_w  = $signed({l_i[DW-1], l_i}) + $signed({r_i[DW-1], r_i});
  assign half_w = sum_w >>> 1;

  always_comb begin
    case (src_e'(sel_i))
      SRC_RIGHT: y_o = r_i;
      SRC_LEFT:  y_o = l_i;
      SRC_MIX:   y_o = half_w[DW-1:0];
      default:   y_o = '0;
    endcase
  end
endmodule

// File: rtl/chmode_ramp.sv
module chmode_ramp
  import chmode_pkg::*;
#(
  parameter int GW = GAIN_FRAC
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step_i,
  input  logic        mute_i,
  output logic [GW:0] gain_o
);
  localparam logic [GW:0] FULL = {1'b1, {GW{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_o <= FULL;
    end else if (step_i) begin
      if (mute_i && gain_o != '0)
        gain_o <= gain_o - 1'b1;
      else if (!mute_i && gain_o != FULL)
        gain_o <= gain_o + 1'b1;
    end
  end

  // R4: the gain moves by at most one step per cycle
  p_gain_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_o == $past(gain_o)) || (gain_o == $past(gain_o) + 1'b1) ||
    (gain_o + 1'b1 == $past(gain_o)));

  // R4: the gain never exceeds unity
  p_gain_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    gain_o <= FULL);

  // R4: a muted gain stays at zero while mute is held
  p_gain_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && mute_i && gain_o == '0) |=> gain_o == '0);

  // R4: without a frame the gain holds
  p_gain_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(gain_o));
endmodule

// File: rtl/chmode_zwatch.sv
module chmode_zwatch
  import chmode_pkg::*;
#(
  parameter int LIMIT = ZRUN_LIMIT
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic accept_i,
  input  logic pair_zero_i,
  output logic sat_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM_C = CW'(LIMIT);

  logic [CW-1:0] cnt_q;
  logic          last_zero_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      last_zero_q <= 1'b0;
    end else begin
      if (accept_i)
        last_zero_q <= pair_zero_i;
      if (accept_i && !pair_zero_i)
        cnt_q <= '0;
      else if (tick_i && (accept_i || last_zero_q) && cnt_q != LIM_C)
        cnt_q <= cnt_q + CW'(1);
    end
  end

  assign sat_o = (cnt_q == LIM_C);

  // R8: a non-zero pair clears the run
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_i && !pair_zero_i) |=> !sat_o && cnt_q == '0);

  // R7: saturation holds until a non-zero pair arrives
  p_sat_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_o && !(accept_i && !pair_zero_i)) |=> sat_o);

  // R7: the count advances by at most one per cycle
  p_cnt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CW'(1)) || (cnt_q == '0));

  // R7: no tick, no advance
  p_cnt_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> (cnt_q == $past(cnt_q)) || (cnt_q == '0));
endmodule

// File: rtl/chmode_proc.sv
module chmode_proc
  import chmode_pkg::*;
#(
  parameter int DW    = SAMPLE_W,
  parameter int GW    = GAIN_FRAC,
  parameter int LIMIT = ZRUN_LIMIT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_left,
  input  logic [DW-1:0] in_right,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_left,
  output logic [DW-1:0] out_right,
  input  logic          bit_tick,
  input  logic [3:0]    route_sel,
  input  logic          mute_req,
  input  logic          op_enable,
  input  logic          zero_det_en,
  input  logic          run_n,
  output logic          zero_forced
);
  localparam int NCH = 2;
  localparam int PW  = DW + GW + 2;

  logic                    accept;
  logic                    pair_zero;
  logic                    zsat;
  logic                    force_all;
  logic                    force_zero;
  logic [GW:0]             gain;
  logic [NCH-1:0][DW-1:0]  routed;
  logic [NCH-1:0][DW-1:0]  scaled;

  assign in_ready  = !out_valid || out_ready;
  assign accept    = in_valid && in_ready;
  assign pair_zero = (in_left == '0) && (in_right == '0);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic signed [PW-1:0] prod;

    chmode_route #(.DW(DW)) u_route (
      .l_i   (in_left),
      .r_i   (in_right),
      .sel_i (route_sel[2*ch +: 2]),
      .y_o   (routed[ch])
    );

    assign prod       = $signed(routed[ch]) * $signed({1'b0, gain});
    assign scaled[ch] = prod[DW+GW-1:GW];
  end

  chmode_ramp #(.GW(GW)) u_ramp (
    .clk    (clk),
    .rst_n  (rst_n),
    .step_i (accept),
    .mute_i (mute_req),
    .gain_o (gain)
  );

  chmode_zwatch #(.LIMIT(LIMIT)) u_zwatch (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (bit_tick),
    .accept_i    (accept),
    .pair_zero_i (pair_zero),
    .sat_o       (zsat)
  );

  assign force_all   = !run_n || op_enable;
  assign force_zero  = force_all || (zero_det_en && zsat && pair_zero);
  assign zero_forced = force_all || (zero_det_en && zsat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_left  <= force_zero ? '0 : scaled[0];
      out_right <= force_zero ? '0 : scaled[1];
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // Bounds of the input pair for the mix check
  logic signed [DW-1:0] lo_s, hi_s;
  assign lo_s = ($signed(in_left) < $signed(in_right)) ? $signed(in_left)  : $signed(in_right);
  assign hi_s = ($signed(in_left) < $signed(in_right)) ? $signed(in_right) : $signed(in_left);

  // R3: the unscaled left mix lies between the two inputs
  p_mix_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !force_zero && route_sel[1:0] == 2'b11 && gain == {1'b1, {GW{1'b0}}})
    |=> ($signed(out_left) >= $past(lo_s)) && ($signed(out_left) <= $past(hi_s)));

  // R5/R6: a forced frame leaves zero on both outputs
  p_forced_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && force_all) |=> (out_left == '0) && (out_right == '0));

  // R9: a stalled output holds
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_left) && $stable(out_right));

  // R1: a silent left field gives a zero left output
  p_silent_left_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && route_sel[1:0] == 2'b00) |=> out_left == '0);
endmodule

// File: tb/tb_chmode_proc.sv
module tb_chmode_proc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] in_left = '0;
  logic [23:0] in_right = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [23:0] out_left;
  logic [23:0] out_right;
  logic        bit_tick = 1'b0;
  logic [3:0]  route_sel = 4'b0110;
  logic        mute_req = 1'b0;
  logic        op_enable = 1'b0;
  logic        zero_det_en = 1'b1;
  logic        run_n = 1'b1;
  logic        zero_forced;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  chmode_proc dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_left(in_left), .in_right(in_right), .out_valid(out_valid),
    .out_ready(out_ready), .out_left(out_left), .out_right(out_right),
    .bit_tick(bit_tick), .route_sel(route_sel), .mute_req(mute_req),
    .op_enable(op_enable), .zero_det_en(zero_det_en), .run_n(run_n),
    .zero_forced(zero_forced)
  );

  typedef struct packed {
    logic [3:0]  sel;
    logic [23:0] l;
    logic [23:0] r;
    logic [23:0] el;
    logic [23:0] er;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{4'b0000, 24'd100,      24'd200,      24'd0,        24'd0},        // R1 R2 silence
    '{4'b0110, 24'd100,      24'd200,      24'd100,      24'd200},      // R2 straight
    '{4'b1001, 24'd100,      24'd200,      24'd200,      24'd100},      // R2 swapped
    '{4'b1111, 24'd100,      24'd201,      24'd150,      24'd150},      // R3 mono
    '{4'b1111, 24'hFFFFFD,   24'd0,        24'hFFFFFE,   24'hFFFFFE},   // R3 floor
    '{4'b1111, 24'h7FFFFF,   24'h7FFFFF,   24'h7FFFFF,   24'h7FFFFF},   // R3 top
    '{4'b1111, 24'h800000,   24'h800000,   24'h800000,   24'h800000},   // R3 bottom
    '{4'b0011, 24'd10,       24'hFFFFEC,   24'hFFFFFB,   24'd0},        // R1 mix left only
    '{4'b1100, 24'h7FFFFF,   24'd1,        24'd0,        24'h400000},   // R2 mix right only
    '{4'b0101, 24'd5,        24'd9,        24'd9,        24'd9}         // R1 right to both
  };

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [23:0] l, input logic [23:0] r);
    @(negedge clk);
    in_left  = l;
    in_right = r;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 out_valid", {23'd0, out_valid}, 24'd0);
    check("R10 in_ready", {23'd0, in_ready}, 24'd1);
    check("R10 zero_forced", {23'd0, zero_forced}, 24'd0);

    // Routing and mix table: R1 R2 R3
    for (int i = 0; i < NV; i++) begin
      route_sel = VEC[i].sel;
      send(VEC[i].l, VEC[i].r);
      check($sformatf("R1 left vec%0d", i), out_left, VEC[i].el);
      check($sformatf("R2 right vec%0d", i), out_right, VEC[i].er);
    end

    // R5 operation enable forces zero
    route_sel = 4'b0110;
    op_enable = 1'b1;
    send(24'd100, 24'd200);
    check("R5 left", out_left, 24'd0);
    check("R5 right", out_right, 24'd0);
    check("R5 flag", {23'd0, zero_forced}, 24'd1);
    op_enable = 1'b0;

    // R6 run control forces zero
    run_n = 1'b0;
    send(24'd300, 24'd400);
    check("R6 left", out_left, 24'd0);
    check("R6 right", out_right, 24'd0);
    check("R6 flag", {23'd0, zero_forced}, 24'd1);
    run_n = 1'b1;
    @(negedge clk);
    check("R6 flag released", {23'd0, zero_forced}, 24'd0);

    // R9 back-pressure
    out_ready = 1'b0;
    send(24'd11, 24'd22);
    check("R9 valid", {23'd0, out_valid}, 24'd1);
    check("R9 ready low", {23'd0, in_ready}, 24'd0);
    in_left = 24'd33; in_right = 24'd44; in_valid = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 hold left", out_left, 24'd11);
    check("R9 hold right", out_right, 24'd22);
    check("R9 hold valid", {23'd0, out_valid}, 24'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 drained left", out_left, 24'd33);
    check("R9 drained right", out_right, 24'd44);

    // R4 soft-mute ramp down then up
    mute_req = 1'b1;
    for (int k = 0; k <= 260; k++) begin
      int g;
      g = (k > 256) ? 0 : 256 - k;
      send(24'h100000, 24'hF00000);
      check($sformatf("R4 down left k%0d", k), out_left, 24'(4096 * g));
      check($sformatf("R4 down right k%0d", k), out_right, 24'(-4096 * g));
    end
    mute_req = 1'b0;
    for (int j = 0; j <= 256; j++) begin
      send(24'h100000, 24'hF00000);
      check($sformatf("R4 up left j%0d", j), out_left, 24'(4096 * j));
    end
    send(24'h100000, 24'hF00000);
    check("R4 unity again", out_left, 24'h100000);

    // R7 zero run
    send(24'd0, 24'd0);
    @(negedge clk);
    bit_tick = 1'b1;
    repeat (65535) @(negedge clk);
    bit_tick = 1'b0;
    check("R7 below limit", {23'd0, zero_forced}, 24'd0);
    bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0;
    check("R7 at limit", {23'd0, zero_forced}, 24'd1);
    zero_det_en = 1'b0;
    @(negedge clk);
    check("R7 detect off flag", {23'd0, zero_forced}, 24'd0);
    send(24'd0, 24'd0);
    check("R7 detect off data", out_left, 24'd0);
    zero_det_en = 1'b1;
    @(negedge clk);
    check("R7 detect on again", {23'd0, zero_forced}, 24'd1);

    // R8 non-zero pair clears the run and passes through
    send(24'd1, 24'd0);
    check("R8 left", out_left, 24'd1);
    check("R8 flag", {23'd0, zero_forced}, 24'd0);

    summary();
    $finish;
  end
endmodule